// File: doc/BRIEF.md
# Sigma-Delta Converter Loop and Boxcar Decimator

This block is the logic half of a first-order sigma-delta analog-to-digital converter. The other half is an external comparator and a single resistor and capacitor that integrate the feedback bit. On every oversampling clock the block takes the comparator decision through a two-flop synchronizer. It registers the inverse of that decision onto a 1-bit feedback pin, so the loop pulls the RC node back toward the input voltage.

The synchronized bit stream is decimated by a plain boxcar average. The block counts the ones over a fixed window of 256 clocks. When the window closes, the count becomes an 8-bit sample, a one-clock valid strobe accompanies it, and the count restarts at once. A 50 MHz bit clock gives samples at about 195 kHz. A window holding 256 ones saturates to 255, so full scale always fits the output width.

Top module: `sdm_adc`

## Requirements
- R1: A change on `cmp_in` reaches `fb_out` on exactly the third rising clock edge after it is sampled: two synchronizer stages, then the feedback register.
- R2: Out of reset, `fb_out` is the logical inverse of the synchronized comparator bit of the previous cycle (comparator 1 gives feedback 0, comparator 0 gives feedback 1).
- R3: Each `sample` equals the number of 1 bits among the 256 consecutive synchronized comparator bits of its window (for example, a 1-in-4 duty cycle gives 64).
- R4: A window in which all 256 bits are 1 yields 255, and the internal count never wraps.
- R5: `sample_valid` is high for exactly one clock, once every 256 clocks. The first pulse follows the 256th rising edge after reset is released.
- R6: A bit that arrives in the last clock slot of a window counts in that window's sample and not in the next window's sample.
- R7: `sample` changes only in the cycle in which `sample_valid` is high, and holds its value between pulses.
- R8: A synchronous active-high `rst` holds `fb_out` at 0, `sample_valid` at 0 and `sample` at 0. It discards any partial count, and the window restarts from its first slot on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator decision from the RC node |
| fb_out | output | 1 | Registered feedback bit driving the RC network |
| sample | output | 8 | Ones count of the last completed window, saturated at 255 |
| sample_valid | output | 1 | One-clock strobe marking a new `sample` |

## Verification
The window close and the accumulation of a 1 bit can fall in the same cycle: the last slot's bit must be added into the emitted sample while the count clears for the next window. The bench provokes this by placing a single 1 on the comparator so that, after the two synchronizer cycles, it lands exactly in slot 255. It then shifts the 1 one slot later, and expects the pair of samples to read 1 then 0 in the first case and 0 then 1 in the second. An all-ones stream drives the same cycle into saturation, where the 256th bit must give 255 rather than wrapping to 0.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int SDM_OUT_W       = 8;
    localparam int SDM_SYNC_STAGES = 2;

    // Add one bit to an unsigned count and clamp at the all-ones value.
    function automatic logic [SDM_OUT_W-1:0] sat_inc(input logic [SDM_OUT_W-1:0] cnt,
                                                     input logic                 bit_in);
        logic [SDM_OUT_W:0] wide;
        wide = {1'b0, cnt} + {{SDM_OUT_W{1'b0}}, bit_in};
        if (wide[SDM_OUT_W]) begin
            sat_inc = {SDM_OUT_W{1'b1}};
        end else begin
            sat_inc = wide[SDM_OUT_W-1:0];
        end
    endfunction

endpackage

// File: rtl/sdm_sync.sv
module sdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_comb begin
            st_d_stage[g] = st_q.chain[g-1];
        end
    end

    logic [STAGES-1:0] st_d_stage;
    logic [STAGES-1:0] next_chain;

    always_comb begin
        next_chain    = st_d_stage;
        next_chain[0] = st_d.chain[0];
    end

    assign st_d_stage[0] = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.chain <= next_chain;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/sdm_pace.sv
module sdm_pace #(
    parameter int WIN_W = 8
) (
    input  logic clk,
    input  logic rst,
    output logic last_slot
);

    typedef struct packed {
        logic [WIN_W-1:0] slot;
    } pace_t;

    pace_t pc_d, pc_q;

    always_comb begin
        pc_d      = pc_q;
        pc_d.slot = pc_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign last_slot = (pc_q.slot == {WIN_W{1'b1}});

    // The window restarts at its first slot right after the last one.
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> !last_slot); // R5

endmodule

// File: rtl/sdm_tally.sv
module sdm_tally
    import sdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_in,
    input  logic                 close,
    output logic [SDM_OUT_W-1:0] sample,
    output logic                 sample_valid
);

    typedef struct packed {
        logic [SDM_OUT_W-1:0] ones;
        logic [SDM_OUT_W-1:0] sample;
        logic                 valid;
    } tally_t;

    tally_t tl_d, tl_q;

    always_comb begin
        tl_d       = tl_q;
        tl_d.valid = 1'b0;
        if (close) begin
            tl_d.sample = sat_inc(tl_q.ones, bit_in);
            tl_d.valid  = 1'b1;
            tl_d.ones   = '0;
        end else begin
            tl_d.ones   = sat_inc(tl_q.ones, bit_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q <= '0;
        end else begin
            tl_q <= tl_d;
        end
    end

    assign sample       = tl_q.sample;
    assign sample_valid = tl_q.valid;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(close)) |-> (tl_q.ones >= $past(tl_q.ones))); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid); // R5

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !sample_valid) |-> $stable(sample)); // R7

endmodule

// File: rtl/sdm_adc.sv
module sdm_adc
    import sdm_pkg::*;
#(
    parameter int SYNC_STAGES = SDM_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmp_in,
    output logic                 fb_out,
    output logic [SDM_OUT_W-1:0] sample,
    output logic                 sample_valid
);

    localparam int WIN_W = SDM_OUT_W;

    typedef struct packed {
        logic fb;
    } loop_t;

    loop_t lp_d, lp_q;
    logic  bit_s;
    logic  last_slot;

    sdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_in),
        .dout (bit_s)
    );

    sdm_pace #(.WIN_W(WIN_W)) u_pace (
        .clk       (clk),
        .rst       (rst),
        .last_slot (last_slot)
    );

    sdm_tally u_tally (
        .clk          (clk),
        .rst          (rst),
        .bit_in       (bit_s),
        .close        (last_slot),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    always_comb begin
        lp_d    = lp_q;
        lp_d.fb = ~bit_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q <= '0;
        end else begin
            lp_q <= lp_d;
        end
    end

    assign fb_out = lp_q.fb;

    AST_FB_INVERT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fb_out == !$past(bit_s))); // R2

    AST_FB_RESET: assert property (@(posedge clk)
        rst |=> !fb_out); // R8

endmodule

// File: tb/sim_sdm_adc.sv
module sim_sdm_adc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_in = 1'b0;
    logic       fb_out;
    logic [7:0] sample;
    logic       sample_valid;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sdm_adc u0 (
        .clk          (clk),
        .rst          (rst),
        .cmp_in       (cmp_in),
        .fb_out       (fb_out),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    // {period, ones per period, expected sample}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{2,   1,   128},
        '{4,   1,   64},
        '{4,   3,   192},
        '{8,   7,   224},
        '{256, 1,   1},
        '{256, 255, 255},
        '{1,   0,   0},
        '{1,   1,   255}
    };

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Runs a periodic pattern; returns the third sample and the gap before it.
    task automatic measure(input int p, input int h, output int got, output int gap);
        int seen = 0;
        int t = 0;
        int last_t = 0;
        got = -1;
        gap = -1;
        while (seen < 3) begin
            @(negedge clk);
            if (sample_valid) begin
                seen++;
                got = sample;
                if (seen == 3) gap = t - last_t;
                last_t = t;
            end
            cmp_in = ((t % p) < h);
            t++;
        end
    endtask

    // After reset release, a single 1 is applied for edge number hot only.
    task automatic hot_run(input int hot, output int s1, output int s2);
        int nv = 0;
        s1 = -1;
        s2 = -1;
        @(negedge clk);
        rst = 1'b1;
        cmp_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int n = 1; n <= 512; n++) begin
            cmp_in = (n == hot);
            @(posedge clk);
            @(negedge clk);
            if (n == 255) check("R5 no pulse before slot 256", int'(sample_valid), 0);
            if (n == 256) check("R5 first pulse at edge 256", int'(sample_valid), 1);
            if (sample_valid) begin
                nv++;
                if (nv == 1) s1 = sample;
                if (nv == 2) s2 = sample;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int got, gap, s1, s2;

        // R8: reset state with cmp_in low (which would otherwise raise fb_out)
        repeat (4) @(negedge clk);
        check("R8 fb_out in reset", int'(fb_out), 0);
        check("R8 sample_valid in reset", int'(sample_valid), 0);
        check("R8 sample in reset", int'(sample), 0);
        rst = 1'b0;

        // R3 R4 R5: duty-cycle table
        for (int i = 0; i < NVEC; i++) begin
            measure(VEC[i][0], VEC[i][1], got, gap);
            check($sformatf("R3/R4 duty %0d/%0d", VEC[i][1], VEC[i][0]), got, VEC[i][2]);
            check("R5 pulse spacing", gap, 256);
        end

        // R8: reset mid-window after a full-scale run clears output state
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 sample cleared", int'(sample), 0);
        check("R8 valid cleared", int'(sample_valid), 0);
        check("R8 fb_out low", int'(fb_out), 0);

        // R6: bit in the last slot belongs to the closing window
        hot_run(254, s1, s2);
        check("R6 last-slot bit in closing window", s1, 1);
        check("R6 last-slot bit absent from next window", s2, 0);
        hot_run(255, s1, s2);
        check("R6 first-slot bit not in previous window", s1, 0);
        check("R6 first-slot bit in new window", s2, 1);

        // R7: sample holds between pulses
        @(negedge clk);
        got = sample;
        repeat (100) begin
            @(negedge clk);
            if (!sample_valid) check("R7 sample held", int'(sample), got);
            else got = sample;
        end

        // R1 R2: feedback latency and polarity
        cmp_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 fb_out high for comparator 0", int'(fb_out), 1);
        cmp_in = 1'b1;
        @(negedge clk);
        check("R1 fb_out after edge 1", int'(fb_out), 1);
        @(negedge clk);
        check("R1 fb_out after edge 2", int'(fb_out), 1);
        @(negedge clk);
        check("R1 fb_out after edge 3", int'(fb_out), 0);
        check("R2 fb_out low for comparator 1", int'(fb_out), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule